// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers single-bit status signals from surrounding line and framing logic into a bank of byte-wide status registers that a processor reads over a simple synchronous bus. Each bit watches one status signal and latches high when that signal reports an event. A bit can be set up to report only its inactive-to-active transition, or both transitions. In dual mode, software tells the direction apart by looking at the live status elsewhere. A read of a status register returns the latched bits and clears the whole register in the same cycle.

Each status bit has a matching enable bit in a writable enable register. A latched bit whose enable is high shows in a summary register, with one bit per status register, and pulls the active-low interrupt output low. A latched bit whose enable is low is still recorded, but stays invisible to the summary and to the interrupt pin. Bits marked reserved by a parameter mask never latch, never enable, and always read as zero.

Top module: `irq_stat_ctrl`

## Requirements
- R1: With its mode bit at 0, a status bit latches on a 0-to-1 change of its source and ignores a 1-to-0 change.
- R2: With its mode bit at 1, a status bit latches on both a 0-to-1 and a 1-to-0 change of its source.
- R3: A latched status bit stays at 1 for any number of cycles until its register is read.
- R4: A read returns the latched byte on rdata one cycle after rd_en and clears every bit of that register, so an immediate second read returns 0.
- R5: An event that reaches a register in the cycle of its clearing read is not lost. The read returns the prior contents, and the next read shows the new bit.
- R6: A latched bit with its enable at 1 drives irq_n low and sets bit k of the summary register (address 0x0C) for status register k.
- R7: A latched bit with its enable at 0 leaves irq_n high and its summary bit at 0.
- R8: irq_n returns high once every enabled latched bit has been cleared by reads.
- R9: Status register k sits at address 0x0B-k and its enable register at 0x1B-k, so register 7 is at 0x04 and 0x14 and register 0 at 0x0B and 0x1B. Bit b of register k watches src_i[8k+b]. Enable registers read back what was written.
- R10: Reserved bits (default: bit 7 of register 0 and bit 7 of register 5) never latch, ignore enable writes, and read as 0.
- R11: A bus write to a status register address changes nothing.
- R12: After reset all status and enable bits are 0, irq_n is high and rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Raw status signals, bit 8k+b feeds register k bit b |
| dual_i | input | 64 | Per-bit mode: 0 rising-edge only, 1 both edges |
| addr_i | input | 8 | Bus address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; a status read clears the register |
| rdata_o | output | 8 | Read data, valid the cycle after rd_en_i |
| irq_n | output | 1 | Active-low interrupt, low while any enabled bit is latched |

## Verification
The source patterns are a lone rise, a lone fall, a rise then a fall under dual mode, an event on a reserved bit, and an event timed to land in the same cycle as a clearing read. The lone fall separates rising-only from dual detection. The same-cycle case separates a read that clears and then sets from one that drops the new event. Each pattern runs with enables both off and on, which shows that the latch path and the interrupt path work apart from each other. The scoreboard checks read data against bytes that are computed from the address map.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
   // which internal register a bus address selects
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_EN   = 2'd2,
      SEL_SUM  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int W            = 8,
   parameter bit DUAL_CAPABLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src,
   input  logic [W-1:0] dual,
   output logic [W-1:0] evt
);
   logic [W-1:0] smp_now;
   logic [W-1:0] smp_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_now <= '0;
         smp_old <= '0;
      end else begin
         smp_now <= src;
         smp_old <= smp_now;
      end
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (DUAL_CAPABLE) begin : g_dual
         assign evt[b] = dual[b] ? (smp_now[b] ^ smp_old[b])
                                 : (smp_now[b] & ~smp_old[b]);
      end else begin : g_rise
         logic unused_mode;
         assign unused_mode = dual[b];
         assign evt[b] = smp_now[b] & ~smp_old[b];
      end
   end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int           W    = 8,
   parameter logic [W-1:0] RSVD = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr,
   input  logic         en_we,
   input  logic [W-1:0] en_wdata,
   output logic [W-1:0] stat,
   output logic [W-1:0] en,
   output logic         req
);
   localparam logic [W-1:0] LIVE = ~RSVD;

   logic [W-1:0] stat_nxt;

   // a clearing read still lets this cycle's events in
   always_comb begin
      stat_nxt = (clr ? '0 : stat) | (evt & LIVE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
      end else begin
         stat <= stat_nxt;
         if (en_we) en <= en_wdata & LIVE;
      end
   end

   assign req = |(stat & en);

   // R3
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((stat & $past(stat)) == $past(stat)));
   // R4
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && evt == '0) |=> (stat == '0));
   // R5
   event_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt & LIVE) != '0) |=> ((stat & $past(evt & LIVE)) == $past(evt & LIVE)));
   // R10
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & RSVD) == '0) && ((en & RSVD) == '0));
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
   import irq_stat_pkg::*;
#(
   parameter int                         NUM_REGS  = 8,
   parameter int                         REG_W     = 8,
   parameter int                         ADDR_W    = 8,
   parameter int                         STAT_BASE = 4,
   parameter int                         EN_BASE   = 20,
   parameter int                         SUM_ADDR  = 12,
   parameter bit                         DUAL_CAPABLE = 1'b1,
   parameter logic [NUM_REGS*REG_W-1:0]  RSVD_MASK = 64'h0000_8000_0000_0080
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_REGS*REG_W-1:0]   src_i,
   input  logic [NUM_REGS*REG_W-1:0]   dual_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic                        wr_en_i,
   input  logic [REG_W-1:0]            wdata_i,
   input  logic                        rd_en_i,
   output logic [REG_W-1:0]            rdata_o,
   output logic                        irq_n
);
   localparam int TOTAL = NUM_REGS * REG_W;
   localparam int STAT_LAST = STAT_BASE + NUM_REGS - 1;
   localparam int EN_LAST   = EN_BASE + NUM_REGS - 1;

   if (NUM_REGS < 1 || NUM_REGS > REG_W) begin : g_bad_regs
      $error("NUM_REGS must lie in 1..REG_W so the summary fits one register");
   end
   if (STAT_LAST >= (1 << ADDR_W) || EN_LAST >= (1 << ADDR_W)
       || SUM_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register map exceeds address width");
   end
   if ((EN_BASE <= STAT_LAST && EN_LAST >= STAT_BASE)
       || (SUM_ADDR >= STAT_BASE && SUM_ADDR <= STAT_LAST)
       || (SUM_ADDR >= EN_BASE && SUM_ADDR <= EN_LAST)) begin : g_bad_overlap
      $error("register windows overlap");
   end

   logic [TOTAL-1:0]    evt_flat;
   logic [REG_W-1:0]    stat  [NUM_REGS];
   logic [REG_W-1:0]    en    [NUM_REGS];
   logic [NUM_REGS-1:0] req;
   logic [NUM_REGS-1:0] st_hit;
   logic [NUM_REGS-1:0] en_hit;
   logic                sum_hit;
   reg_sel_e            sel;
   logic [REG_W-1:0]    rd_next;

   irq_edge_detect #(
      .W            (TOTAL),
      .DUAL_CAPABLE (DUAL_CAPABLE)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_i),
      .dual  (dual_i),
      .evt   (evt_flat)
   );

   assign sum_hit = (addr_i == ADDR_W'(SUM_ADDR));

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STAT_LAST - k);
      localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_LAST - k);

      assign st_hit[k] = (addr_i == ST_A);
      assign en_hit[k] = (addr_i == EN_A);

      irq_status_bank #(
         .W    (REG_W),
         .RSVD (RSVD_MASK[k*REG_W +: REG_W])
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt_flat[k*REG_W +: REG_W]),
         .clr      (rd_en_i && st_hit[k]),
         .en_we    (wr_en_i && en_hit[k]),
         .en_wdata (wdata_i),
         .stat     (stat[k]),
         .en       (en[k]),
         .req      (req[k])
      );
   end

   always_comb begin
      if (|st_hit)      sel = SEL_STAT;
      else if (|en_hit) sel = SEL_EN;
      else if (sum_hit) sel = SEL_SUM;
      else              sel = SEL_NONE;
   end

   always_comb begin
      rd_next = '0;
      unique case (sel)
         SEL_STAT: for (int k = 0; k < NUM_REGS; k++)
                      if (st_hit[k]) rd_next = stat[k];
         SEL_EN:   for (int k = 0; k < NUM_REGS; k++)
                      if (en_hit[k]) rd_next = en[k];
         SEL_SUM:  rd_next = REG_W'(req);
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_o <= '0;
      else if (rd_en_i) rdata_o <= rd_next;
   end

   assign irq_n = ~(|req);

   // R6
   enabled_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat[0] & en[0])) |-> !irq_n);
   // R8
   irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> irq_n);
   // R11
   stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && st_hit[0] && !rd_en_i && evt_flat[REG_W-1:0] == '0)
      |=> (stat[0] == $past(stat[0])));
endmodule

// File: tb/irq_stat_ctrl_test.sv
module irq_stat_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic [63:0] dual = '0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wdata = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rdata;
   logic        irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb [$];

   always #10 clk = ~clk;

   irq_stat_ctrl uut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .dual_i(dual),
      .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
      .rd_en_i(rd_en), .rdata_o(rdata), .irq_n(irq_n)
   );

   // monitor: a read strobe seen at a rising edge yields data by the next falling edge
   logic rd_seen = 1'b0;
   always @(posedge clk) rd_seen <= rd_en;
   always @(negedge clk) begin
      if (rd_seen && sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (rdata !== it.exp) begin
            errors++;
            $display("FAIL %s rdata=%02h expected=%02h", it.tag, rdata, it.exp);
         end
      end
   end

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      item_t it;
      it.exp = e; it.tag = tag;
      @(negedge clk);
      sb.push_back(it);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // change one source and wait until the event is latched
   task automatic drive(input int idx, input logic v);
      @(negedge clk);
      src[idx] = v;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      checks++;
      if (irq_n !== e) begin
         errors++;
         $display("FAIL %s irq_n=%0b expected=%0b", tag, irq_n, e);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      chk_irq(1'b1, "R12");
      checks++;
      if (rdata !== 8'h00) begin
         errors++;
         $display("FAIL R12 rdata=%02h expected=00", rdata);
      end
      rd(8'h0B, 8'h00, "R12 status");
      rd(8'h1B, 8'h00, "R12 enable");
      rd(8'h0C, 8'h00, "R12 summary");

      // R1 rising-edge only
      drive(0, 1'b1);
      rd(8'h0B, 8'h01, "R1 rise");
      rd(8'h0B, 8'h00, "R4 second read");
      drive(0, 1'b0);
      rd(8'h0B, 8'h00, "R1 fall ignored");

      // R2 dual-edge on register 1 bit 1
      dual[9] = 1'b1;
      drive(9, 1'b1);
      rd(8'h0A, 8'h02, "R2 rise");
      drive(9, 1'b0);
      rd(8'h0A, 8'h02, "R2 fall");

      // R3 hold, R7 disabled stays silent
      drive(18, 1'b1);
      repeat (6) @(negedge clk);
      chk_irq(1'b1, "R7");
      rd(8'h0C, 8'h00, "R7 summary");
      rd(8'h09, 8'h04, "R3 held");

      // R10 enable reserved bit, R9 enable map
      wr(8'h1B, 8'hFF);
      rd(8'h1B, 8'h7F, "R10 enable reserved");
      wr(8'h1B, 8'h00);
      wr(8'h18, 8'h08);
      rd(8'h18, 8'h08, "R9 enable readback");

      // R6 enabled event, R8 release
      drive(27, 1'b1);
      chk_irq(1'b0, "R6");
      rd(8'h0C, 8'h08, "R6 summary");
      rd(8'h08, 8'h08, "R6 status");
      @(negedge clk);
      chk_irq(1'b1, "R8");

      // R11 status write ignored
      drive(1, 1'b1);
      wr(8'h0B, 8'h00);
      wr(8'h0B, 8'hFF);
      rd(8'h0B, 8'h02, "R11");

      // R10 reserved source bit
      drive(7, 1'b1);
      drive(47, 1'b1);
      rd(8'h0B, 8'h00, "R10 reg0");
      rd(8'h06, 8'h00, "R10 reg5");

      // R5 event in the cycle of the clearing read
      drive(32, 1'b1);
      @(negedge clk);
      src[33] = 1'b1;
      rd(8'h07, 8'h01, "R5 read old");
      rd(8'h07, 8'h02, "R5 kept");

      // R9 top register
      drive(63, 1'b1);
      rd(8'h04, 8'h80, "R9 reg7");

      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R4 pending reads=%0d expected=0", sb.size());
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule